// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Output

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words are 18 bits wide and the storage depth is a power of two set by a parameter. The writer offers a word with a write enable on its own clock. The reader takes words with a read enable on the other clock. Both pointers cross between the domains as Gray codes through two-flop synchronisers. As a result, a flag that the far side releases reaches the observing side about two of its own cycles later.

One configuration input, captured while reset is held low, selects one of two output styles. In the standard style the read flag means "empty", and each accepted read enable loads the next word into the output register. In the fall-through style the read flag means "a word is waiting". The oldest word reaches the output register without any read enable, and a read enable consumes it. Because that register then holds a word of its own, the buffer holds one word more than the RAM depth.

Two threshold flags report when the buffer is nearly empty and when it is nearly full. Their offsets are captured during reset, or default to 7 when offset loading is not enabled. The nearly-empty flag is updated on read clock edges only, and the nearly-full flag on write clock edges only.

Top module: `fifo_dc18`

## Requirements
- R1: Words leave in the order they were accepted, with all 18 bits intact, across the two clock domains.
- R2: The style select `cfg_fwft` (0 = standard, 1 = fall-through) takes effect only when captured on clock edges while `rst_n` is low. Changes after reset have no effect.
- R3: In standard style, `rd_flag` = 1 means empty. A read enable while not empty puts the next word on `rd_data` after that read clock edge. A read enable while empty is ignored and `rd_data` holds its value.
- R4: In fall-through style, `rd_flag` = 1 means a word is on `rd_data`. The first word written into an empty buffer appears there with no read enable. A read enable while `rd_flag` = 1 consumes the word, and `rd_data` stays stable while no read is made.
- R5: `full` is 1 when the stored word count equals the capacity: 2^AW in standard style, 2^AW + 1 in fall-through style. Writes while `full` = 1 are ignored.
- R6: With offset n, `almost_empty` is 1 when the word count is at most n in standard style, or at most n + 1 in fall-through style. It changes only on read clock edges.
- R7: With offset m, `almost_full` is 1 when the word count is at least capacity − m. It changes only on write clock edges.
- R8: When `cfg_ofs_en` = 1 during reset, the offsets are taken from `cfg_ae_ofs` and `cfg_af_ofs`. Otherwise both are 7. Values presented after reset have no effect.
- R9: Reset empties the buffer. In standard style `rd_flag` is then 1, in fall-through style it is 0. `full` = 0, `almost_empty` = 1 and `almost_full` = 0.
- R10: Each pointer's Gray code changes by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low; configuration is captured while low |
| cfg_fwft | input | 1 | Style select: 0 standard, 1 fall-through |
| cfg_ofs_en | input | 1 | 1 = capture offsets from inputs, 0 = use 7 |
| cfg_ae_ofs | input | AW | Nearly-empty offset n |
| cfg_af_ofs | input | AW | Nearly-full offset m |
| wr_en | input | 1 | Write enable |
| wr_data | input | DW | Write word |
| full | output | 1 | Buffer at capacity |
| almost_full | output | 1 | Count at least capacity − m |
| rd_en | input | 1 | Read enable |
| rd_data | output | DW | Output register |
| rd_flag | output | 1 | Standard: empty; fall-through: word ready |
| almost_empty | output | 1 | Count at most n (n + 1 in fall-through) |

## Verification
The case where a read frees a slot and a write arrives at the same moment is provoked in standard style. The bench fills the buffer to capacity, then keeps offering writes on every write cycle while the reader drains six words in parallel. Each write is judged as accepted or dropped from the `full` value the writer sees just before its edge. The full sequence is then drained and compared word by word. A missing, duplicated or overwritten word shows up as a data mismatch or a wrong final count.

// File: rtl/fifo_dc18.sv
module fifo_dc18 #(
  parameter int DW      = 18,
  parameter int AW      = 8,
  parameter int DEF_OFS = 7
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          cfg_fwft,
  input  logic          cfg_ofs_en,
  input  logic [AW-1:0] cfg_ae_ofs,
  input  logic [AW-1:0] cfg_af_ofs,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write side
  logic          fwft_w;
  logic [AW-1:0] af_m;
  logic [PW-1:0] wptr, wgray, rgs1, rgs2, ugs1, ugs2;
  logic [PW-1:0] rptr_s, upt_s, wr_used, cap_w;
  logic          wr_go;

  // read side
  logic          fwft_r;
  logic [AW-1:0] ae_n;
  logic [PW-1:0] rptr, upt, rgray, ugray, wgs1, wgs2;
  logic [PW-1:0] wptr_s, ram_cnt, rd_words;
  logic          qv, ram_any, load, take;

  always_ff @(posedge wr_clk)
    if (!rst_n) begin
      fwft_w <= cfg_fwft;
      af_m   <= cfg_ofs_en ? cfg_af_ofs : AW'(DEF_OFS);
    end

  assign rptr_s      = g2b(rgs2);
  assign upt_s       = g2b(ugs2);
  assign wr_used     = wptr - upt_s;
  assign cap_w       = fwft_w ? PW'(DEPTH + 1) : PW'(DEPTH);
  assign full        = (wptr - rptr_s == PW'(DEPTH)) || (wr_used == cap_w);
  assign almost_full = wr_used >= cap_w - PW'(af_m);
  assign wr_go       = wr_en && !full;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      rgs1  <= '0;
      rgs2  <= '0;
      ugs1  <= '0;
      ugs2  <= '0;
    end else begin
      rgs1 <= rgray;
      rgs2 <= rgs1;
      ugs1 <= ugray;
      ugs2 <= ugs1;
      if (wr_go) begin
        wptr  <= wptr + 1'b1;
        wgray <= b2g(wptr + 1'b1);
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wptr[AW-1:0]] <= wr_data;

  always_ff @(posedge rd_clk)
    if (!rst_n) begin
      fwft_r <= cfg_fwft;
      ae_n   <= cfg_ofs_en ? cfg_ae_ofs : AW'(DEF_OFS);
    end

  assign wptr_s       = g2b(wgs2);
  assign ram_cnt      = wptr_s - rptr;
  assign ram_any      = ram_cnt != '0;
  assign load         = ram_any && (fwft_r ? (!qv || rd_en) : rd_en);
  assign take         = rd_en && (fwft_r ? qv : ram_any);
  assign rd_flag      = fwft_r ? qv : !ram_any;
  assign rd_words     = ram_cnt + PW'(fwft_r && qv);
  assign almost_empty = rd_words <= PW'(ae_n) + PW'(fwft_r);

  always_ff @(posedge rd_clk or negedge rst_n)
    if (!rst_n) begin
      rptr    <= '0;
      rgray   <= '0;
      upt     <= '0;
      ugray   <= '0;
      wgs1    <= '0;
      wgs2    <= '0;
      qv      <= 1'b0;
      rd_data <= '0;
    end else begin
      wgs1 <= wgray;
      wgs2 <= wgs1;
      qv   <= fwft_r && (load || (qv && !rd_en));
      if (load) begin
        rd_data <= mem[rptr[AW-1:0]];
        rptr    <= rptr + 1'b1;
        rgray   <= b2g(rptr + 1'b1);
      end
      if (take) begin
        upt   <= upt + 1'b1;
        ugray <= b2g(upt + 1'b1);
      end
    end
endmodule

// File: rtl/fifo_dc18_chk.sv
module fifo_dc18_chk #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          fwft_w,
  input logic          fwft_r,
  input logic          wr_en,
  input logic          full,
  input logic          almost_full,
  input logic [AW:0]   wptr,
  input logic [AW:0]   wgray,
  input logic          rd_en,
  input logic          rd_flag,
  input logic          almost_empty,
  input logic [DW-1:0] rd_data,
  input logic [AW:0]   rptr,
  input logic [AW:0]   rgray,
  input logic [AW:0]   ugray
);
  a_r5_write_blocked: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && wr_en) |=> $stable(wptr));

  a_r3_read_blocked: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_r && rd_flag && rd_en) |=> ($stable(rptr) && $stable(rd_data)));

  a_r4_word_held: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft_r && rd_flag && !rd_en) |=> (rd_flag && $stable(rd_data)));

  a_r6_empty_is_low: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_r && rd_flag) |-> almost_empty);

  a_r7_full_is_high: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!fwft_w && full) |-> almost_full);

  a_r10_wgray_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  a_r10_rgray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1);

  a_r10_ugray_step: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(ugray ^ $past(ugray)) <= 1);
endmodule

bind fifo_dc18 fifo_dc18_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .fwft_w(fwft_w), .fwft_r(fwft_r),
  .wr_en(wr_en), .full(full), .almost_full(almost_full),
  .wptr(wptr), .wgray(wgray),
  .rd_en(rd_en), .rd_flag(rd_flag), .almost_empty(almost_empty),
  .rd_data(rd_data), .rptr(rptr), .rgray(rgray), .ugray(ugray)
);

// File: tb/test_fifo_dc18.sv
`timescale 1ns/100ps
module test_fifo_dc18;
  localparam int AW = 3;
  localparam int DW = 18;
  localparam int D  = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic cfg_fwft = 0, cfg_ofs_en = 0;
  logic [AW-1:0] cfg_ae_ofs = '0, cfg_af_ofs = '0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic full, almost_full, rd_flag, almost_empty;
  logic [DW-1:0] rd_data;

  always #2.5 wr_clk = ~wr_clk;
  always #3.6 rd_clk = ~rd_clk;

  fifo_dc18 #(.DW(DW), .AW(AW)) i_fifo_dc18 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .cfg_fwft(cfg_fwft), .cfg_ofs_en(cfg_ofs_en),
    .cfg_ae_ofs(cfg_ae_ofs), .cfg_af_ofs(cfg_af_ofs),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag), .almost_empty(almost_empty)
  );

  // {fwft, ofs_en, n[2:0], m[2:0], writes[4:0], reads[4:0]}
  localparam logic [17:0] VECS [13] = '{
    {1'b0, 1'b1, 3'd2, 3'd2, 5'd3,  5'd0},
    {1'b0, 1'b1, 3'd2, 3'd2, 5'd5,  5'd3},
    {1'b0, 1'b1, 3'd2, 3'd2, 5'd6,  5'd0},
    {1'b0, 1'b1, 3'd0, 3'd0, 5'd12, 5'd0},
    {1'b0, 1'b1, 3'd3, 3'd1, 5'd12, 5'd8},
    {1'b1, 1'b1, 3'd2, 3'd2, 5'd1,  5'd0},
    {1'b1, 1'b1, 3'd2, 3'd2, 5'd3,  5'd0},
    {1'b1, 1'b1, 3'd2, 3'd2, 5'd4,  5'd0},
    {1'b1, 1'b1, 3'd2, 3'd3, 5'd12, 5'd0},
    {1'b1, 1'b1, 3'd2, 3'd3, 5'd12, 5'd4},
    {1'b1, 1'b0, 3'd1, 3'd1, 5'd4,  5'd0},
    {1'b0, 1'b0, 3'd4, 3'd2, 5'd3,  5'd0},
    {1'b1, 1'b1, 3'd0, 3'd0, 5'd2,  5'd2}
  };

  int checks = 0, fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seq = 18'h01000;
  logic [DW-1:0] last_word = '0;
  bit tb_fw;
  int tb_n, tb_m;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit fw, input bit en, input int n, input int m);
    @(negedge wr_clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    cfg_fwft = fw; cfg_ofs_en = en;
    cfg_ae_ofs = AW'(n); cfg_af_ofs = AW'(m);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1;
    q.delete();
    tb_fw = fw;
    tb_n = en ? n : 7;
    tb_m = en ? m : 7;
    @(negedge wr_clk);
    cfg_fwft = ~fw; cfg_ofs_en = ~en;
    cfg_ae_ofs = ~AW'(n); cfg_af_ofs = ~AW'(m);
  endtask

  task automatic push_words(input int nwr);
    for (int i = 0; i < nwr; i++) begin
      @(negedge wr_clk);
      wr_en = 1;
      wr_data = seq;
      if (!full) q.push_back(seq);
      seq++;
    end
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop_words(input int k);
    int got = 0;
    int guard = 0;
    bit pend = 0;
    logic [DW-1:0] expw = '0;
    while ((got < k || pend) && guard < 1000) begin
      @(negedge rd_clk);
      guard++;
      if (!tb_fw) begin
        if (pend) begin
          chk("R1 R3 R10 read order", 32'(rd_data), 32'(expw));
          last_word = rd_data;
          pend = 0;
        end
        if (got < k && !rd_flag) begin
          rd_en = 1;
          expw = (q.size() > 0) ? q.pop_front() : 18'h3FFFF;
          pend = 1;
          got++;
        end else rd_en = 0;
      end else begin
        if (got < k && rd_flag) begin
          expw = (q.size() > 0) ? q.pop_front() : 18'h3FFFF;
          chk("R1 R4 R10 read order", 32'(rd_data), 32'(expw));
          last_word = rd_data;
          rd_en = 1;
          got++;
        end else rd_en = 0;
      end
    end
    if (guard >= 1000) chk("R1 read stalled", 32'(got), 32'(k));
    @(negedge rd_clk);
    rd_en = 0;
  endtask

  task automatic check_flags();
    int words = q.size();
    int cap = tb_fw ? D + 1 : D;
    repeat (12) @(negedge rd_clk);
    @(negedge wr_clk);
    chk("R5 full", 32'(full), 32'(words == cap));
    chk("R7 R8 almost_full", 32'(almost_full), 32'(words >= cap - tb_m));
    @(negedge rd_clk);
    if (tb_fw) chk("R4 ready flag", 32'(rd_flag), 32'(words > 0));
    else       chk("R3 empty flag", 32'(rd_flag), 32'(words == 0));
    chk("R6 R8 almost_empty", 32'(almost_empty), 32'(words <= tb_n + int'(tb_fw)));
  endtask

  task automatic check_reset_state();
    repeat (12) @(negedge rd_clk);
    @(negedge wr_clk);
    chk("R9 full after reset", 32'(full), 32'(0));
    chk("R9 almost_full after reset", 32'(almost_full), 32'(0));
    @(negedge rd_clk);
    chk("R9 rd_flag after reset", 32'(rd_flag), 32'(!tb_fw));
    chk("R9 almost_empty after reset", 32'(almost_empty), 32'(1));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    foreach (VECS[i]) begin
      logic [17:0] v = VECS[i];
      do_reset(v[17], v[16], int'(v[15:13]), int'(v[12:10]));
      check_reset_state();
      push_words(int'(v[9:5]));
      pop_words(int'(v[4:0]));
      check_flags();
    end

    // R5: write attempts while full, with a drain running alongside
    do_reset(0, 0, 0, 0);
    push_words(12);
    check_flags();
    fork
      push_words(6);
      pop_words(6);
    join
    check_flags();
    pop_words(q.size());
    check_flags();

    // R3: read enable while empty leaves rd_data unchanged
    repeat (3) @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    @(negedge rd_clk);
    chk("R3 data held on empty read", 32'(rd_data), 32'(last_word));
    chk("R3 still empty", 32'(rd_flag), 32'(1));

    // R2: style input flipped after reset has no effect
    do_reset(0, 1, 2, 2);
    push_words(1);
    repeat (12) @(negedge rd_clk);
    chk("R2 standard style kept", 32'(rd_flag), 32'(0));
    do_reset(1, 1, 2, 2);
    push_words(1);
    repeat (12) @(negedge rd_clk);
    chk("R2 fall-through style kept", 32'(rd_flag), 32'(1));
    chk("R4 first word without read", 32'(rd_data), 32'(q[0]));

    // R9: reset in the middle of traffic
    do_reset(0, 1, 1, 1);
    push_words(5);
    do_reset(0, 1, 1, 1);
    check_reset_state();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule